// File: doc/BRIEF.md
# 64-bit Compare Timer

This block is a machine timer for a single processor. A 64-bit counter runs freely while the timer is switched on. A prescaler divides the clock, and on each divided tick the counter advances by a programmable step. Software places a 64-bit compare value in two 32-bit words. When the counter reaches or passes that value, the block raises a raw timer-pending line. If the interrupt is enabled, it also latches a sticky interrupt flag.

Software talks to the block through a simple single-cycle 32-bit register port. Writes take effect at the clock edge. Read data is combinational and is valid while a read request is held. The sticky flag is cleared by writing a one to it, and a test register lets software force the flag. A two-state machine holds the sticky flag:

- **IDLE** is the state when no interrupt is latched.
- **IDLE → LATCHED**: the machine moves to LATCHED on a set condition, which is a compare hit or a forced test write, either one gated by the interrupt enable.
- **LATCHED → IDLE**: the machine returns to IDLE on a write-one-to-clear, but only in a cycle that has no set condition.

Top module: `cmp_timer`

## Requirements
- R1: The register port uses byte offsets. The offsets are:
  - RUN_CTL at 0x000
  - TICK_CFG at 0x100
  - COUNT_LO at 0x104
  - COUNT_HI at 0x108
  - MATCH_LO at 0x10C
  - MATCH_HI at 0x110
  - IRQ_EN at 0x114
  - IRQ_STS at 0x118
  - IRQ_FORCE at 0x11C

  Any other offset reads as zero and ignores writes. An offset that is not a multiple of four also reads as zero and ignores writes.
- R2: Reset values are as follows:
  - TICK_CFG resets to 0x00010000, which is step 1 and prescale 0.
  - Both MATCH words reset to 0xFFFFFFFF.
  - The counter resets to zero.
  - RUN_CTL, IRQ_EN, IRQ_STS and IRQ_FORCE reset to zero.
  - Both outputs are low during reset.
- R3: While RUN_CTL bit 0 is clear:
  - the counter does not advance;
  - the prescaler does not advance;
  - timer_pending stays low;
  - no compare hit sets IRQ_STS.
- R4: TICK_CFG bits 11:0 hold the prescale value P, and bits 23:16 hold the step value S. While the timer runs, the counter adds S once every P+1 clocks. A prescaler that is already at or above a newly written P wraps on the next clock.
- R5: timer_pending is high exactly when the timer runs and MATCH <= COUNT, with both taken as 64-bit values. It rises in the cycle after a write that moves MATCH into the past. It falls in the cycle after a write that moves MATCH ahead of the counter.
- R6: IRQ_STS bit 0 becomes 1 one clock after a compare hit, but only while IRQ_EN bit 0 is 1. A hit with IRQ_EN bit 0 at 0 leaves IRQ_STS unchanged.
- R7: Writing IRQ_STS with bit 0 set clears the flag, unless a set condition occurs in the same cycle. A set condition wins over the clear.
- R8: Writing IRQ_FORCE with bit 0 set sets IRQ_STS bit 0 when IRQ_EN bit 0 is 1, and has no effect on the flag otherwise. IRQ_FORCE reads back bit 0 of the last value written to it.
- R9: timer_irq equals IRQ_STS bit 0 AND IRQ_EN bit 0.
- R10: COUNT_LO and COUNT_HI are each writable on their own, and a write leaves the other word untouched. A counter write takes priority over the tick in that cycle. Reads of the counter words return the live counter.
- R11: The counter and the compare logic are a full 64 bits wide. A carry out of the low word advances the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset into the 0x400 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read request is held |
| timer_irq | output | 1 | Level interrupt |
| timer_pending | output | 1 | Raw compare condition |

## Verification
The main compare path is exercised with a range of match values:
- a match value that is already behind the counter, which shows that a hit occurs on the write itself and not only as the counter advances;
- a value ahead of the counter, which shows that pending deasserts;
- values that differ only in the high word, which shows that the full 64-bit comparison is in use.

Counting is driven with a large prescale and small step, and then with a zero prescale and the largest step. Each setting tells apart wrong tick spacing from wrong increment size. The counter is also preloaded just below a low-word wrap, which exposes a missing carry. Clear and force writes are issued both while a hit is live and while it is not, which separates the priority of set over clear from plain clearing.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned CNT_W    = 2 * DATA_W;
    localparam int unsigned STEP_LSB = 16;

    // word indices inside the window (byte offset / 4)
    localparam int unsigned IDX_RUN    = 'h000;
    localparam int unsigned IDX_CFG    = 'h040;
    localparam int unsigned IDX_CNT_LO = 'h041;
    localparam int unsigned IDX_CNT_HI = 'h042;
    localparam int unsigned IDX_CMP_LO = 'h043;
    localparam int unsigned IDX_CMP_HI = 'h044;
    localparam int unsigned IDX_IE     = 'h045;
    localparam int unsigned IDX_STS    = 'h046;
    localparam int unsigned IDX_FORCE  = 'h047;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RUN,
        SEL_CFG,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_IE,
        SEL_STS,
        SEL_FORCE
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_LATCHED
    } irq_state_e;

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned PRE_W  = 12,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              sts_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              run_o,
    output logic [PRE_W-1:0]  prescale_o,
    output logic [STEP_W-1:0] step_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              ie_o,
    output logic              cnt_lo_wr_o,
    output logic              cnt_hi_wr_o,
    output logic              sts_w1c_o,
    output logic              force_set_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    reg_sel_e          sel;
    logic              wr;
    logic              run_q;
    logic [PRE_W-1:0]  pre_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              ie_q;
    logic              force_q;

    always_comb begin
        sel = SEL_NONE;
        if (addr_i[1:0] == 2'b00) begin
            case (addr_i[ADDR_W-1:2])
                IDX_W'(IDX_RUN):    sel = SEL_RUN;
                IDX_W'(IDX_CFG):    sel = SEL_CFG;
                IDX_W'(IDX_CNT_LO): sel = SEL_CNT_LO;
                IDX_W'(IDX_CNT_HI): sel = SEL_CNT_HI;
                IDX_W'(IDX_CMP_LO): sel = SEL_CMP_LO;
                IDX_W'(IDX_CMP_HI): sel = SEL_CMP_HI;
                IDX_W'(IDX_IE):     sel = SEL_IE;
                IDX_W'(IDX_STS):    sel = SEL_STS;
                IDX_W'(IDX_FORCE):  sel = SEL_FORCE;
                default:            sel = SEL_NONE;
            endcase
        end
    end

    assign wr = req_i & we_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pre_q   <= '0;
            step_q  <= STEP_W'(1);
            cmp_q   <= '1;
            ie_q    <= 1'b0;
            force_q <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_RUN:    run_q   <= wdata_i[0];
                SEL_CFG: begin
                    pre_q  <= wdata_i[PRE_W-1:0];
                    step_q <= wdata_i[STEP_LSB +: STEP_W];
                end
                SEL_CMP_LO: cmp_q[DATA_W-1:0]     <= wdata_i;
                SEL_CMP_HI: cmp_q[CNT_W-1:DATA_W] <= wdata_i;
                SEL_IE:     ie_q    <= wdata_i[0];
                SEL_FORCE:  force_q <= wdata_i[0];
                default: ;
            endcase
        end
    end

    assign cnt_lo_wr_o = wr && (sel == SEL_CNT_LO);
    assign cnt_hi_wr_o = wr && (sel == SEL_CNT_HI);
    assign sts_w1c_o   = wr && (sel == SEL_STS)   && wdata_i[0];
    assign force_set_o = wr && (sel == SEL_FORCE) && wdata_i[0];

    always_comb begin
        rdata_o = '0;
        if (req_i && !we_i) begin
            unique case (sel)
                SEL_NONE:   rdata_o = '0;
                SEL_RUN:    rdata_o = DATA_W'(run_q);
                SEL_CFG:    rdata_o = (DATA_W'(step_q) << STEP_LSB) | DATA_W'(pre_q);
                SEL_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
                SEL_CNT_HI: rdata_o = cnt_i[CNT_W-1:DATA_W];
                SEL_CMP_LO: rdata_o = cmp_q[DATA_W-1:0];
                SEL_CMP_HI: rdata_o = cmp_q[CNT_W-1:DATA_W];
                SEL_IE:     rdata_o = DATA_W'(ie_q);
                SEL_STS:    rdata_o = DATA_W'(sts_i);
                SEL_FORCE:  rdata_o = DATA_W'(force_q);
            endcase
        end
    end

    assign run_o      = run_q;
    assign prescale_o = pre_q;
    assign step_o     = step_q;
    assign cmp_o      = cmp_q;
    assign ie_o       = ie_q;

    // R1
    bad_addr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i[1:0] != 2'b00) |-> (rdata_o == '0));

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
    import cmp_timer_pkg::*;
#(
    parameter int unsigned PRE_W  = 12,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PRE_W-1:0]  prescale_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              lo_wr_i,
    input  logic              hi_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = run_i && (pre_q >= prescale_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run_i) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (lo_wr_i || hi_wr_i) begin
            if (lo_wr_i) cnt_q[DATA_W-1:0]     <= wdata_i;
            if (hi_wr_i) cnt_q[CNT_W-1:DATA_W] <= wdata_i;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(step_i);
        end
    end

    assign cnt_o = cnt_q;

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !lo_wr_i && !hi_wr_i) |=> $stable(cnt_q));

    // R4
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !lo_wr_i && !hi_wr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(step_i))));

    // R10
    lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i && !hi_wr_i) |=> (cnt_q[DATA_W-1:0] == $past(wdata_i)
                                   && $stable(cnt_q[CNT_W-1:DATA_W])));

endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq
    import cmp_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic ie_i,
    input  logic force_i,
    input  logic w1c_i,
    output logic sts_o
);

    irq_state_e state_q, state_d;
    logic       set;

    assign set = ie_i && (hit_i || force_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (set)            state_d = IRQ_LATCHED;
            IRQ_LATCHED: if (w1c_i && !set)  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        sts_o = (state_q == IRQ_LATCHED);
    end

    // R6
    set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> sts_o);

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !sts_o) |=> !sts_o);

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i && !set) |=> !sts_o);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned PRE_W  = 12,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              timer_irq,
    output logic              timer_pending
);

    logic              run;
    logic [PRE_W-1:0]  prescale;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  cmp;
    logic [CNT_W-1:0]  cnt;
    logic              ie;
    logic              sts;
    logic              cnt_lo_wr;
    logic              cnt_hi_wr;
    logic              sts_w1c;
    logic              force_set;
    logic              hit;

    cmp_timer_regs #(
        .ADDR_W (ADDR_W),
        .PRE_W  (PRE_W),
        .STEP_W (STEP_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (bus_req),
        .we_i        (bus_we),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .cnt_i       (cnt),
        .sts_i       (sts),
        .rdata_o     (bus_rdata),
        .run_o       (run),
        .prescale_o  (prescale),
        .step_o      (step),
        .cmp_o       (cmp),
        .ie_o        (ie),
        .cnt_lo_wr_o (cnt_lo_wr),
        .cnt_hi_wr_o (cnt_hi_wr),
        .sts_w1c_o   (sts_w1c),
        .force_set_o (force_set)
    );

    cmp_timer_count #(
        .PRE_W  (PRE_W),
        .STEP_W (STEP_W)
    ) count_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .prescale_i (prescale),
        .step_i     (step),
        .lo_wr_i    (cnt_lo_wr),
        .hi_wr_i    (cnt_hi_wr),
        .wdata_i    (bus_wdata),
        .cnt_o      (cnt)
    );

    assign hit = run && (cmp <= cnt);

    cmp_timer_irq irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .ie_i    (ie),
        .force_i (force_set),
        .w1c_i   (sts_w1c),
        .sts_o   (sts)
    );

    assign timer_pending = hit;
    assign timer_irq     = sts & ie;

    // R5
    pend_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_pending |-> run);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq && !$past(ie)) |-> $rose(ie));

endmodule

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        pend;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string rd_tag = "R1";

    always #2 clk = ~clk;

    cmp_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req       (req),
        .bus_we        (we),
        .bus_addr      (addr),
        .bus_wdata     (wdata),
        .bus_rdata     (rdata),
        .timer_irq     (irq),
        .timer_pending (pend)
    );

    // behavioural reference model
    longint unsigned m_cnt, m_cmp;
    int unsigned     m_pre, m_prescale, m_step;
    bit              m_run, m_ie, m_sts, m_force;

    always @(posedge clk) begin
        bit wr, tick, hit, set, clr;
        if (!rst_n) begin
            m_cnt = 0; m_cmp = '1; m_pre = 0; m_prescale = 0; m_step = 1;
            m_run = 0; m_ie = 0; m_sts = 0; m_force = 0;
        end else begin
            wr   = req && we;
            tick = m_run && (m_pre >= m_prescale);
            hit  = m_run && (m_cmp <= m_cnt);
            set  = m_ie && (hit || (wr && addr == 10'h11C && wdata[0]));
            clr  = wr && addr == 10'h118 && wdata[0];
            if (set) m_sts = 1;
            else if (clr) m_sts = 0;
            if (m_run) m_pre = tick ? 0 : m_pre + 1;
            if (wr && (addr == 10'h104 || addr == 10'h108)) begin
                if (addr == 10'h104) m_cnt[31:0]  = wdata;
                else                 m_cnt[63:32] = wdata;
            end else if (tick) begin
                m_cnt = m_cnt + m_step;
            end
            if (wr) begin
                case (addr)
                    10'h000: m_run = wdata[0];
                    10'h100: begin m_prescale = wdata[11:0]; m_step = wdata[23:16]; end
                    10'h10C: m_cmp[31:0]  = wdata;
                    10'h110: m_cmp[63:32] = wdata;
                    10'h114: m_ie = wdata[0];
                    10'h11C: m_force = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [9:0] a);
        case (a)
            10'h000: return {31'b0, m_run};
            10'h100: return (32'(m_step) << 16) | 32'(m_prescale);
            10'h104: return m_cnt[31:0];
            10'h108: return m_cnt[63:32];
            10'h10C: return m_cmp[31:0];
            10'h110: return m_cmp[63:32];
            10'h114: return {31'b0, m_ie};
            10'h118: return {31'b0, m_sts};
            10'h11C: return {31'b0, m_force};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 timer_pending", 64'(pend), 64'(m_run && (m_cmp <= m_cnt)));
            check("R9 timer_irq", 64'(irq), 64'(m_sts && m_ie));
            if (req && !we) check(rd_tag, 64'(rdata), 64'(exp_read(addr)));
        end
    end

    task automatic wr_reg(logic [9:0] a, logic [31:0] d);
        @(negedge clk); #1;
        req = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); #1;
        req = 0; we = 0;
    endtask

    task automatic rd_reg(logic [9:0] a, string tag);
        @(negedge clk); #1;
        req = 1; we = 0; addr = a; rd_tag = tag;
        @(negedge clk); #1;
        req = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R2: outputs low in reset
        check("R2 irq in reset", 64'(irq), 64'h0);
        check("R2 pending in reset", 64'(pend), 64'h0);
        #1 rst_n = 1;

        // R2: reset values
        rd_reg(10'h100, "R2 cfg");
        rd_reg(10'h10C, "R2 match lo");
        rd_reg(10'h110, "R2 match hi");
        rd_reg(10'h000, "R2 run");
        rd_reg(10'h114, "R2 ie");
        rd_reg(10'h118, "R2 sts");
        rd_reg(10'h11C, "R2 force");
        rd_reg(10'h104, "R2 count");

        // R1: unmapped and misaligned
        rd_reg(10'h004, "R1 unmapped");
        rd_reg(10'h3FC, "R1 unmapped top");
        rd_reg(10'h101, "R1 misaligned");
        wr_reg(10'h200, 32'hFFFF_FFFF);
        wr_reg(10'h102, 32'h0000_0000);
        rd_reg(10'h100, "R1 cfg after ignored writes");

        // R3: stopped timer holds
        wr_reg(10'h100, 32'h0003_0002);
        idle(8);
        rd_reg(10'h104, "R3 count held");

        // R4: prescale 2, step 3
        wr_reg(10'h000, 32'h1);
        idle(13);
        rd_reg(10'h104, "R4 count p2 s3");
        wr_reg(10'h100, 32'h00FF_0000);
        idle(5);
        rd_reg(10'h104, "R4 count p0 s255");
        wr_reg(10'h100, 32'h0001_0FFF);
        idle(4);
        rd_reg(10'h104, "R4 count large prescale");

        // R10 / R11: preload near low-word wrap
        wr_reg(10'h100, 32'h0010_0000);
        wr_reg(10'h108, 32'h0000_0000);
        wr_reg(10'h104, 32'hFFFF_FFE0);
        rd_reg(10'h104, "R10 count lo");
        idle(3);
        rd_reg(10'h108, "R11 carry into hi");
        rd_reg(10'h104, "R11 lo after wrap");

        // R5: match in past, then ahead
        wr_reg(10'h110, 32'h0000_0000);
        wr_reg(10'h10C, 32'h0000_0000);
        idle(3);
        wr_reg(10'h110, 32'h0000_0010);
        idle(2);
        // R6: hits with ie=0 leave the flag clear
        rd_reg(10'h118, "R6 no latch without enable");
        wr_reg(10'h114, 32'h1);
        wr_reg(10'h110, 32'h0000_0000);
        idle(3);
        rd_reg(10'h118, "R6 latched");

        // R7: clear loses while hit live, wins once match moved ahead
        wr_reg(10'h118, 32'h1);
        rd_reg(10'h118, "R7 set beats clear");
        wr_reg(10'h110, 32'h0000_0010);
        idle(2);
        rd_reg(10'h118, "R7 still sticky");
        wr_reg(10'h118, 32'h1);
        rd_reg(10'h118, "R7 cleared");

        // R8: force with and without enable
        wr_reg(10'h11C, 32'h1);
        rd_reg(10'h118, "R8 forced");
        rd_reg(10'h11C, "R8 force readback");
        wr_reg(10'h118, 32'h1);
        wr_reg(10'h114, 32'h0);
        wr_reg(10'h11C, 32'h1);
        rd_reg(10'h118, "R8 force blocked");
        wr_reg(10'h11C, 32'h0);
        wr_reg(10'h114, 32'h1);

        // R3: stopped timer raises nothing
        wr_reg(10'h000, 32'h0);
        wr_reg(10'h110, 32'h0000_0000);
        idle(4);
        rd_reg(10'h118, "R3 no hit while stopped");

        // R10: high word written alone
        wr_reg(10'h108, 32'hABCD_0000);
        rd_reg(10'h108, "R10 count hi");
        rd_reg(10'h104, "R10 lo untouched");

        idle(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule